// File: doc/BRIEF.md
# Tuner Synthesiser Control Target

This block is an I2C target that holds the programming state of a frequency synthesiser used for tuning. A bus controller addresses it, writes bytes that set a 15-bit division ratio, four charge-pump and test control bits and six output-port enables, and reads back one status byte. The status byte carries a power-on flag, a lock flag, three port input levels and a 3-bit converter code. SCL and SDA arrive as plain inputs. The block drives SDA only through a pull-low enable, and the surrounding open-drain pad provides the wired-AND.

The target answers one fixed address code and one code picked by a 2-bit select input, so several synthesisers can share a bus. In a write transfer, the top bit of each data byte that opens a pair chooses what the pair loads: the divider (high part, then low part) or the control settings followed by the port enables. Any number of pairs may follow one address. A byte that is cut short by a stop or a repeated start changes nothing. The power-on flag is set by reset and survives until a read transfer is closed by a stop.

Top module: `tuner_ctl_slave`

## Requirements
- R1: The target acknowledges an address byte only if its upper five bits are 11000 and its bits 2:1 are either 01 or equal to `addr_sel_i`. Any other address gets no acknowledge, and the target stays silent until the next start. Bit 0 set to 1 means read and 0 means write.
- R2: After an accepted address, and after every complete write data byte, the target pulls SDA low for the acknowledge clock. It begins pulling only while SCL is low.
- R3: In a write transfer, a pair-opening byte with bit 7 = 0 supplies divider bits 14..8 in its bits 6..0, and the following byte supplies bits 7..0. `div_o` changes only when the second byte has been acknowledged, so it never holds half of a new ratio.
- R4: A pair-opening byte with bit 7 = 1 is a control byte laid out 1, CP, T1, T0, 1, 1, 1, OS from bit 7 to bit 0. Its four bits appear on `cp_o`, `t1_o`, `t0_o` and `os_o` once it is acknowledged. The next byte is a port byte: its bits 7..2 drive `port_en_o[5:0]` (P7 down to P2), where 1 means on, and its bits 1..0 are ignored.
- R5: Any number of byte pairs may follow one address within a single transfer. Each pair is decoded by the bit-7 rule of its first byte.
- R6: A data byte that ends before all eight bits and its acknowledge clock have arrived leaves every register output unchanged. The next transfer starts decoding from a pair-opening byte.
- R7: In a read transfer, the target sends the status byte MSB first as POR, FL (`lock_i`), `port_lvl_i[2:0]` (P7, P5, P4), `adc_i[2:0]`. The values are captured when each byte starts.
- R8: In a read transfer, the target sends another status byte only when the controller acknowledged the previous one. After a missing acknowledge it releases SDA.
- R9: POR reads as 1 after reset. It is cleared only by a stop that ends a read transfer, and nothing sets it again apart from reset.
- R10: After reset, `div_o` = 0, all control bits are 0, all ports are off and SDA is released.
- R11: A repeated start abandons the byte in progress and any half-received pair, and address matching starts afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| addr_sel_i | input | 2 | Selected programmable address code |
| lock_i | input | 1 | Phase-lock flag for the status byte |
| port_lvl_i | input | 3 | Levels of ports P7, P5, P4 |
| adc_i | input | 3 | Converter code for the status byte |
| div_o | output | 15 | Division ratio |
| cp_o | output | 1 | Charge-pump current select |
| t1_o | output | 1 | Test-mode select |
| t0_o | output | 1 | Charge-pump disable |
| os_o | output | 1 | Drive amplifier off |
| port_en_o | output | 6 | Port enables, bit 5 = P7 ... bit 0 = P2 |

## Verification
The assertions check on every cycle that the divider, the control bits and the port enables change only in the cycle after an acknowledge was being driven. They also check that SDA is pulled only while SCL is low and that the power-on flag never rises again. The bench scenarios cover the behaviour that depends on byte order and transfer history: pair decoding by bit 7, address acceptance for each select code, the discarding of cut-off bytes, restart after a repeated start, how long a read continues, and when POR is cleared.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } link_st_t;

  localparam logic [4:0] ADDR_FIXED  = 5'b11000;
  localparam logic [1:0] ADDR_ALWAYS = 2'b01;
  localparam int         BYTE_BITS   = 8;
endpackage

// File: rtl/tcs_line_sync.sv
module tcs_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic              last_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
          last_q  <= 1'b1;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], line_i[g]};
          last_q  <= chain_q[STAGES-1];
        end
      end

      assign level_o[g] = chain_q[STAGES-1];
      assign rise_o[g]  = chain_q[STAGES-1] & ~last_q;
      assign fall_o[g]  = ~chain_q[STAGES-1] & last_q;
    end
  endgenerate
endmodule

// File: rtl/tcs_link.sv
module tcs_link
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status_byte,
  output logic       sda_pull,
  output logic       byte_ok,
  output logic [7:0] rx_byte,
  output logic       frame_start,
  output logic       rd_end
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  link_st_t         st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       rx_q, rx_n, tx_q, tx_n;
  logic             pull_q, pull_n;
  logic             rw_q, rw_n, rdf_q, rdf_n, mack_q, mack_n;
  logic             start_ev, stop_ev, addr_hit;

  assign start_ev = sda_fall & scl_s;
  assign stop_ev  = sda_rise & scl_s;
  assign addr_hit = (rx_q[7:3] == ADDR_FIXED) &&
                    ((rx_q[2:1] == ADDR_ALWAYS) || (rx_q[2:1] == addr_sel));

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; rx_n = rx_q; tx_n = tx_q;
    pull_n = pull_q; rw_n = rw_q; rdf_n = rdf_q; mack_n = mack_q;
    byte_ok = 1'b0; frame_start = 1'b0; rd_end = 1'b0;
    if (start_ev) begin
      st_n = ST_ADDR; cnt_n = '0; pull_n = 1'b0; rdf_n = 1'b0;
      frame_start = 1'b1;
    end else if (stop_ev) begin
      st_n = ST_IDLE; pull_n = 1'b0; rd_end = rdf_q; rdf_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && cnt_q != FULL) begin
            rx_n  = {rx_q[6:0], sda_s};
            cnt_n = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == FULL) begin
            if (st_q == ST_WDATA) begin
              pull_n = 1'b1; st_n = ST_WACK;
            end else if (addr_hit) begin
              pull_n = 1'b1; st_n = ST_AACK; rw_n = rx_q[0];
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_n = '0;
          if (rw_q) begin
            tx_n = status_byte; pull_n = ~status_byte[7];
            st_n = ST_RDATA; rdf_n = 1'b1;
          end else begin
            pull_n = 1'b0; st_n = ST_WDATA;
          end
        end
        ST_WACK: if (scl_fall) begin
          pull_n = 1'b0; cnt_n = '0; byte_ok = 1'b1; st_n = ST_WDATA;
        end
        ST_RDATA: begin
          if (scl_rise) cnt_n = cnt_q + 1'b1;
          if (scl_fall) begin
            if (cnt_q == FULL) begin
              pull_n = 1'b0; st_n = ST_RACK;
            end else begin
              tx_n = {tx_q[6:0], 1'b0}; pull_n = ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              tx_n = status_byte; pull_n = ~status_byte[7];
              cnt_n = '0; st_n = ST_RDATA;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; rx_q <= '0; tx_q <= '0;
      pull_q <= 1'b0; rw_q <= 1'b0; rdf_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; rx_q <= rx_n; tx_q <= tx_n;
      pull_q <= pull_n; rw_q <= rw_n; rdf_q <= rdf_n; mack_q <= mack_n;
    end
  end

  assign sda_pull = pull_q;
  assign rx_byte  = rx_q;
endmodule

// File: rtl/tcs_regfile.sv
module tcs_regfile #(
  parameter int DIV_W  = 15,
  parameter int PORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_ok,
  input  logic [7:0]        rx_byte,
  input  logic              frame_start,
  input  logic              rd_end,
  output logic [DIV_W-1:0]  div,
  output logic              cp,
  output logic              t1,
  output logic              t0,
  output logic              os,
  output logic [PORT_W-1:0] port_en,
  output logic              por
);
  localparam int HI_W = DIV_W - 8;

  logic [DIV_W-1:0]  div_q, div_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [3:0]        ctl_q, ctl_n;
  logic [PORT_W-1:0] port_q, port_n;
  logic              second_q, second_n, kind_q, kind_n, por_q, por_n;

  always_comb begin
    div_n = div_q; hi_n = hi_q; ctl_n = ctl_q; port_n = port_q;
    second_n = second_q; kind_n = kind_q; por_n = por_q;
    if (frame_start) second_n = 1'b0;
    if (rd_end) por_n = 1'b0;
    if (byte_ok) begin
      if (!second_q) begin
        second_n = 1'b1;
        kind_n   = rx_byte[7];
        if (rx_byte[7]) ctl_n = {rx_byte[6], rx_byte[5], rx_byte[4], rx_byte[0]};
        else            hi_n  = rx_byte[HI_W-1:0];
      end else begin
        second_n = 1'b0;
        if (kind_q) port_n = rx_byte[7 -: PORT_W];
        else        div_n  = {hi_q, rx_byte};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; hi_q <= '0; ctl_q <= '0; port_q <= '0;
      second_q <= 1'b0; kind_q <= 1'b0; por_q <= 1'b1;
    end else begin
      div_q <= div_n; hi_q <= hi_n; ctl_q <= ctl_n; port_q <= port_n;
      second_q <= second_n; kind_q <= kind_n; por_q <= por_n;
    end
  end

  assign div     = div_q;
  assign cp      = ctl_q[3];
  assign t1      = ctl_q[2];
  assign t0      = ctl_q[1];
  assign os      = ctl_q[0];
  assign port_en = port_q;
  assign por     = por_q;
endmodule

// File: rtl/tuner_ctl_slave.sv
module tuner_ctl_slave #(
  parameter int DIV_W       = 15,
  parameter int PORT_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic [2:0]        port_lvl_i,
  input  logic [2:0]        adc_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              cp_o,
  output logic              t1_o,
  output logic              t0_o,
  output logic              os_o,
  output logic [PORT_W-1:0] port_en_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] lvl, rise, fall;
  logic       byte_ok, frame_start, rd_end, por_flag;
  logic [7:0] rx_byte, status_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tcs_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_int_n), .line_i({sda_i, scl_i}),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign status_byte = {por_flag, lock_i, port_lvl_i, adc_i};

  tcs_link i_link (
    .clk(clk), .rst_n(rst_int_n),
    .scl_s(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
    .sda_s(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .addr_sel(addr_sel_i), .status_byte(status_byte),
    .sda_pull(sda_pull_o), .byte_ok(byte_ok), .rx_byte(rx_byte),
    .frame_start(frame_start), .rd_end(rd_end)
  );

  tcs_regfile #(.DIV_W(DIV_W), .PORT_W(PORT_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n),
    .byte_ok(byte_ok), .rx_byte(rx_byte),
    .frame_start(frame_start), .rd_end(rd_end),
    .div(div_o), .cp(cp_o), .t1(t1_o), .t0(t0_o), .os(os_o),
    .port_en(port_en_o), .por(por_flag)
  );
endmodule

// File: rtl/tuner_ctl_slave_chk.sv
module tuner_ctl_slave_chk #(
  parameter int DIV_W  = 15,
  parameter int PORT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic [DIV_W-1:0]  div_o,
  input logic              cp_o,
  input logic              t1_o,
  input logic              t0_o,
  input logic              os_o,
  input logic [PORT_W-1:0] port_en_o,
  input logic              por_flag
);
  // R3: ratio moves only right after an acknowledge was held
  p_div_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_o) |-> $past(sda_pull_o));

  // R4, R6: control bits move only after an acknowledged byte
  p_ctl_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cp_o, t1_o, t0_o, os_o}) |-> $past(sda_pull_o));

  // R4, R6: port enables move only after an acknowledged byte
  p_port_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_en_o) |-> $past(sda_pull_o));

  // R2: the target starts pulling SDA only while SCL is low
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R9: the power-on flag never sets again outside reset
  p_por_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(por_flag));
endmodule

bind tuner_ctl_slave tuner_ctl_slave_chk #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .div_o(div_o), .cp_o(cp_o), .t1_o(t1_o), .t0_o(t0_o), .os_o(os_o),
  .port_en_o(port_en_o), .por_flag(por_flag)
);

// File: tb/test_tuner_ctl_slave.sv
module test_tuner_ctl_slave;
  localparam int CLK_NS = 10;
  localparam int Q      = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1, sda_drv = 1'b1;
  logic        sda_pull, sda_line;
  logic [1:0]  addr_sel = 2'b00;
  logic        lock = 1'b0;
  logic [2:0]  lvl = 3'b000, adc = 3'b000;
  logic [14:0] div;
  logic        cp, t1, t0, os;
  logic [5:0]  ports;
  int          errors = 0, checks = 0;

  always #(CLK_NS / 2) clk = ~clk;
  assign sda_line = sda_drv & ~sda_pull;

  tuner_ctl_slave i_tuner_ctl_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .addr_sel_i(addr_sel), .lock_i(lock),
    .port_lvl_i(lvl), .adc_i(adc), .div_o(div), .cp_o(cp), .t1_o(t1),
    .t0_o(t0), .os_o(os), .port_en_o(ports)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    sda_drv = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; wq(Q); scl = 1'b1; wq(Q);
    sda_drv = 1'b1; wq(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_drv = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic t_reset;
    check("R10 div", div, 0);
    check("R10 ctl", {cp, t1, t0, os}, 0);
    check("R10 ports off", ports, 0);
    check("R10 sda released", sda_pull, 0);
  endtask

  task automatic t_divider;
    logic a;
    bus_start; put_byte(8'hC2, a); check("R1 fixed code ack", a, 1);
    put_byte(8'h5A, a); check("R2 data ack", a, 1);
    check("R3 div holds after high part", div, 0);
    put_byte(8'h3C, a);
    check("R3 div loaded", div, 15'h5A3C);
    bus_stop;
  endtask

  task automatic t_ctl_port;
    logic a;
    bus_start; put_byte(8'hC2, a);
    put_byte(8'hDF, a);
    check("R4 control bits", {cp, t1, t0, os}, 4'b1011);
    put_byte(8'hB3, a);
    check("R4 port byte", ports, 6'b101100);
    check("R4 div untouched", div, 15'h5A3C);
    bus_stop;
  endtask

  task automatic t_multi;
    logic a;
    bus_start; put_byte(8'hC2, a);
    put_byte(8'h8E, a); put_byte(8'h00, a);
    check("R5 first pair ctl", {cp, t1, t0, os}, 0);
    check("R5 first pair ports", ports, 0);
    put_byte(8'h01, a); put_byte(8'h02, a);
    check("R5 second pair div", div, 15'h0102);
    put_byte(8'hE0, a); put_byte(8'hFC, a);
    bus_stop;
    check("R5 third pair ctl", {cp, t1, t0, os}, 4'b1100);
    check("R5 third pair ports", ports, 6'h3F);
  endtask

  task automatic t_addr;
    logic a;
    addr_sel = 2'b10;
    bus_start; put_byte(8'hC4, a); bus_stop; check("R1 selected code 10", a, 1);
    bus_start; put_byte(8'hC6, a); bus_stop; check("R1 unselected code 11", a, 0);
    bus_start; put_byte(8'hC2, a); bus_stop; check("R1 code 01 always", a, 1);
    addr_sel = 2'b00;
    bus_start; put_byte(8'hC0, a); bus_stop; check("R1 selected code 00", a, 1);
    bus_start; put_byte(8'hD2, a); bus_stop; check("R1 wrong upper bits", a, 0);
    bus_start; put_byte(8'hC4, a); put_byte(8'h00, a); bus_stop;
    check("R1 no ack on data after miss", a, 0);
    check("R1 div unchanged after miss", div, 15'h0102);
  endtask

  task automatic t_truncate;
    logic a;
    bus_start; put_byte(8'hC2, a); put_byte(8'h12, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_stop;
    check("R6 cut low part keeps div", div, 15'h0102);
    bus_start; put_byte(8'hC2, a);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    bus_stop;
    check("R6 cut control keeps ctl", {cp, t1, t0, os}, 4'b1100);
    bus_start; put_byte(8'hC2, a); put_byte(8'h44, a); put_byte(8'h55, a); bus_stop;
    check("R6 next transfer starts a pair", div, 15'h4455);
  endtask

  task automatic t_restart;
    logic a;
    bus_start; put_byte(8'hC2, a); put_byte(8'h11, a);
    bus_start; put_byte(8'hC2, a); check("R11 address after restart", a, 1);
    put_byte(8'h22, a); put_byte(8'h33, a); bus_stop;
    check("R11 pair restarted", div, 15'h2233);
  endtask

  task automatic t_status;
    logic a, b;
    logic [7:0] d;
    lock = 1'b1; lvl = 3'b101; adc = 3'b011;
    bus_start; put_byte(8'hC3, a); check("R1 read address ack", a, 1);
    get_byte(1'b1, d); check("R9 POR kept through writes", d, 8'hEB);
    get_byte(1'b1, d); check("R8 second byte after ack", d, 8'hEB);
    get_byte(1'b0, d); check("R7 third byte", d, 8'hEB);
    get_bit(b); check("R8 released after no ack", b, 1);
    bus_stop;
    lock = 1'b0; lvl = 3'b010; adc = 3'b100;
    bus_start; put_byte(8'hC3, a);
    get_byte(1'b0, d); check("R9 POR cleared, R7 fields", d, 8'h14);
    bus_stop;
  endtask

  initial begin
    wq(5); rst_n = 1'b1; wq(10);
    t_reset;
    t_divider;
    t_ctl_port;
    t_multi;
    t_addr;
    t_truncate;
    t_restart;
    t_status;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule